// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the condition flags of an 8-bit processor core. Every cycle it may take a zero, nibble-carry and carry update from the arithmetic unit, under a per-flag update mask. It may also take a software write to the three arithmetic flag bits and power-state events from the sleep and watchdog logic. When one instruction both writes the register and updates flags, the flag logic wins. The write data is then dropped for all three arithmetic bits, and any flag the mask leaves out keeps its value. This is why a clear of the register leaves carry and nibble carry untouched but still sets zero.

The two power-state bits record the cause of the last wake or reset. They follow only the sleep, watchdog-clear and watchdog-timeout events, and a register write can never change them. All inputs are plain per-cycle strobes and levels with no handshake. The block accepts an update every cycle and never pushes back. The read-back is a register output: it shows the new value in the cycle after the inputs that caused it.

Top module: `status_flag_reg`

## Requirements
- R1: The read-back layout is bit 0 carry, bit 1 nibble carry, bit 2 zero, bit 3 power-down, bit 4 time-out; bits 7 to 5 always read 0.
- R2: While `rst_n` is low the read-back is 0x18: time-out and power-down are 1, and zero, nibble carry and carry are 0.
- R3: A write with `flag_mask_i` = 0 loads `wr_flags_i[2:0]` into bits 2:0 one cycle later.
- R4: A write in the same cycle as a nonzero `flag_mask_i` loses all three of its bits. Masked flags take the flag logic value and unmasked flags hold their old value.
- R5: With `flag_mask_i[2]` set, zero becomes 1 exactly when `res_i` is all zeros.
- R6: With `flag_mask_i[1]` set, nibble carry takes `nib_carry_i`, the carry out of bit 3. In subtraction, 1 means no borrow.
- R7: With `flag_mask_i[0]` set, carry comes from `csel_i`: 0 or 3 selects `carry_i`, the carry out of the MSB, where 1 means no borrow in subtraction. 1 selects `src_msb_i` (rotate left) and 2 selects `src_lsb_i` (rotate right).
- R8: Without a write, a flag whose mask bit is 0 holds its value.
- R9: Time-out goes to 1 on `wdt_clr_i` or `sleep_i` and to 0 on `wdt_to_i`; the timeout wins when they coincide.
- R10: Power-down goes to 1 on `wdt_clr_i` and to 0 on `sleep_i`; sleep wins when both coincide.
- R11: A register write never changes time-out or power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| res_i | input | 8 | ALU result, used for zero |
| carry_i | input | 1 | Carry out of MSB (1 = no borrow on subtract) |
| nib_carry_i | input | 1 | Carry out of bit 3 (1 = no borrow on subtract) |
| src_msb_i | input | 1 | Source MSB, shifted into carry by rotate left |
| src_lsb_i | input | 1 | Source LSB, shifted into carry by rotate right |
| csel_i | input | 2 | Carry source select |
| flag_mask_i | input | 3 | Per-flag update enable: bit 2 zero, bit 1 nibble carry, bit 0 carry |
| wr_en_i | input | 1 | Register write strobe |
| wr_flags_i | input | 3 | Write data for bits 2:0 |
| sleep_i | input | 1 | Sleep event strobe |
| wdt_clr_i | input | 1 | Watchdog-clear event strobe |
| wdt_to_i | input | 1 | Watchdog-timeout event strobe |
| stat_o | output | 8 | Status read-back |

## Verification
The hardest case to bring about is a write dropped under a partial mask, where the value that survives must differ from the write data. The stimulus first gives the register a known pattern, 1s or 0s, through plain writes. It then issues a clear-style write together with a zero-only update, and later a nonzero write together with a nibble-carry-only update. This shows the write was dropped for all three bits, not just for the masked one. Coinciding power events are driven in pairs to fix each priority.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int BIT_C  = 0;
  localparam int BIT_DC = 1;
  localparam int BIT_Z  = 2;
  localparam int BIT_PD = 3;
  localparam int BIT_TO = 4;
  localparam int STAT_W = 8;
  localparam int FLAG_N = 3;

  typedef enum logic [1:0] {
    CSRC_ADD = 2'd0,
    CSRC_MSB = 2'd1,
    CSRC_LSB = 2'd2,
    CSRC_ALT = 2'd3
  } csrc_e;
endpackage

// File: rtl/sflag_arith.sv
module sflag_arith
  import sflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              nib_carry_i,
  input  logic              src_msb_i,
  input  logic              src_lsb_i,
  input  logic [1:0]        csel_i,
  input  logic [FLAG_N-1:0] mask_i,
  input  logic              wr_en_i,
  input  logic [FLAG_N-1:0] wr_flags_i,
  output logic [FLAG_N-1:0] flags_o
);
  logic [FLAG_N-1:0] flags_q, flags_d, logic_val;
  logic              carry_sel;
  logic              any_upd;

  always_comb begin
    unique case (csel_i)
      CSRC_MSB: carry_sel = src_msb_i;
      CSRC_LSB: carry_sel = src_lsb_i;
      default:  carry_sel = carry_i;
    endcase
  end

  always_comb begin
    logic_val         = '0;
    logic_val[BIT_Z]  = (res_i == '0);
    logic_val[BIT_DC] = nib_carry_i;
    logic_val[BIT_C]  = carry_sel;
  end

  assign any_upd = |mask_i;

  always_comb begin
    flags_d = flags_q;
    if (any_upd) begin
      for (int i = 0; i < FLAG_N; i++)
        if (mask_i[i]) flags_d[i] = logic_val[i];
    end else if (wr_en_i) begin
      flags_d = wr_flags_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R4
  drop_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && any_upd && !mask_i[BIT_C]) |=> (flags_o[BIT_C] == $past(flags_o[BIT_C])));
  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i[BIT_Z] |=> (flags_o[BIT_Z] == ($past(res_i) == '0)));
  // R3
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !any_upd) |=> (flags_o == $past(wr_flags_i)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !any_upd) |=> $stable(flags_o));
endmodule

// File: rtl/sflag_power.sv
module sflag_power (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic wdt_clr_i,
  input  logic wdt_to_i,
  output logic to_o,
  output logic pd_o
);
  logic to_q, pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else begin
      if (wdt_to_i)                 to_q <= 1'b0;
      else if (wdt_clr_i || sleep_i) to_q <= 1'b1;
      if (sleep_i)                  pd_q <= 1'b0;
      else if (wdt_clr_i)           pd_q <= 1'b1;
    end
  end

  assign to_o = to_q;
  assign pd_o = pd_q;

  // R9
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to_i |=> !to_o);
  // R10
  sleep_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !pd_o);
  // R9
  no_event_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_to_i && !wdt_clr_i && !sleep_i) |=> $stable(to_o));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              nib_carry_i,
  input  logic              src_msb_i,
  input  logic              src_lsb_i,
  input  logic [1:0]        csel_i,
  input  logic [2:0]        flag_mask_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_flags_i,
  input  logic              sleep_i,
  input  logic              wdt_clr_i,
  input  logic              wdt_to_i,
  output logic [7:0]        stat_o
);
  logic [FLAG_N-1:0] arith_flags;
  logic              to_bit, pd_bit;

  sflag_arith #(.DATA_W(DATA_W)) u_arith (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_i      (res_i),
    .carry_i    (carry_i),
    .nib_carry_i(nib_carry_i),
    .src_msb_i  (src_msb_i),
    .src_lsb_i  (src_lsb_i),
    .csel_i     (csel_i),
    .mask_i     (flag_mask_i),
    .wr_en_i    (wr_en_i),
    .wr_flags_i (wr_flags_i),
    .flags_o    (arith_flags)
  );

  sflag_power u_power (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_i  (sleep_i),
    .wdt_clr_i(wdt_clr_i),
    .wdt_to_i (wdt_to_i),
    .to_o     (to_bit),
    .pd_o     (pd_bit)
  );

  // R1: fixed bit layout, upper bits zero
  always_comb begin
    stat_o         = '0;
    stat_o[BIT_C]  = arith_flags[BIT_C];
    stat_o[BIT_DC] = arith_flags[BIT_DC];
    stat_o[BIT_Z]  = arith_flags[BIT_Z];
    stat_o[BIT_PD] = pd_bit;
    stat_o[BIT_TO] = to_bit;
  end

  // R11
  write_no_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !sleep_i && !wdt_clr_i && !wdt_to_i) |=> $stable(stat_o[BIT_TO:BIT_PD]));
endmodule

// File: tb/status_flag_reg_bench.sv
module status_flag_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] res_i;
  logic       carry_i, nib_carry_i, src_msb_i, src_lsb_i;
  logic [1:0] csel_i;
  logic [2:0] flag_mask_i;
  logic       wr_en_i;
  logic [2:0] wr_flags_i;
  logic       sleep_i, wdt_clr_i, wdt_to_i;
  logic [7:0] stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  status_flag_reg u_status_flag_reg (
    .clk(clk), .rst_n(rst_n), .res_i(res_i), .carry_i(carry_i),
    .nib_carry_i(nib_carry_i), .src_msb_i(src_msb_i), .src_lsb_i(src_lsb_i),
    .csel_i(csel_i), .flag_mask_i(flag_mask_i), .wr_en_i(wr_en_i),
    .wr_flags_i(wr_flags_i), .sleep_i(sleep_i), .wdt_clr_i(wdt_clr_i),
    .wdt_to_i(wdt_to_i), .stat_o(stat_o)
  );

  // mask, csel, res, msb, lsb, carry, nib, wr, wdata, expected
  localparam logic [28:0] VEC [12] = '{
    {3'b111, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 8'h1F}, // R5 R6 R7
    {3'b111, 2'd0, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h18}, // R5 R6 R7
    {3'b001, 2'd1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h19}, // R7 rotate left
    {3'b001, 2'd2, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h18}, // R7 rotate right
    {3'b001, 2'd2, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h19}, // R7 rotate right
    {3'b000, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 8'h1F}, // R3 R11 R1
    {3'b000, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h1F}, // R8
    {3'b100, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h1F}, // R4 clear
    {3'b000, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h18}, // R3
    {3'b010, 2'd0, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 8'h18}, // R4
    {3'b110, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 8'h1E}, // R5 R6
    {3'b001, 2'd3, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h1F}  // R7 no borrow
  };

  task automatic idle();
    res_i = 8'h11; carry_i = 0; nib_carry_i = 0; src_msb_i = 0; src_lsb_i = 0;
    csel_i = 2'd0; flag_mask_i = 3'b000; wr_en_i = 0; wr_flags_i = 3'd0;
    sleep_i = 0; wdt_clr_i = 0; wdt_to_i = 0;
  endtask

  task automatic chk(input logic [7:0] exp, input string tag);
    checks++;
    if (stat_o !== exp) begin
      errors++;
      $display("FAIL %s: stat_o=%02h expected %02h", tag, stat_o, exp);
    end
  endtask

  task automatic events(input logic s, input logic c, input logic t,
                        input logic [7:0] exp, input string tag);
    @(negedge clk);
    sleep_i = s; wdt_clr_i = c; wdt_to_i = t;
    @(negedge clk);
    idle();
    chk(exp, tag);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(8'h18, "R2 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    chk(8'h18, "R2 after release");

    for (int i = 0; i < 12; i++) begin
      flag_mask_i = VEC[i][28:26];
      csel_i      = VEC[i][25:24];
      res_i       = VEC[i][23:16];
      src_msb_i   = VEC[i][15];
      src_lsb_i   = VEC[i][14];
      carry_i     = VEC[i][13];
      nib_carry_i = VEC[i][12];
      wr_en_i     = VEC[i][11];
      wr_flags_i  = VEC[i][10:8];
      @(negedge clk);
      idle();
      chk(VEC[i][7:0], $sformatf("R1-table vector %0d (R3 R4 R5 R6 R7 R8)", i));
    end

    events(1, 0, 0, 8'h17, "R9 R10 sleep");
    events(0, 0, 1, 8'h07, "R9 timeout");
    @(negedge clk);
    wr_en_i = 1; wr_flags_i = 3'd7;
    @(negedge clk);
    idle();
    chk(8'h07, "R11 write keeps power bits");
    events(0, 1, 0, 8'h1F, "R9 R10 watchdog clear");
    events(0, 1, 1, 8'h0F, "R9 timeout beats clear");
    events(1, 1, 0, 8'h17, "R10 sleep beats clear");
    events(1, 0, 1, 8'h07, "R9 R10 sleep with timeout");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(8'h18, "R2 mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(8'h18, "R2 R8 idle after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule